// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract ALU

This block is the arithmetic slice of a small 8-bit processor core. It computes add-with-carry and subtract-with-borrow in either plain binary or packed-BCD form. It also handles accumulator increment and decrement and the bit-test operation. It returns a result byte, the four condition flags (negative, overflow, zero, carry) and a mask that tells the register file which of those flags the operation is allowed to write.

Operands are captured on the rising clock edge when `in_valid` is high. The result, flags and mask appear one cycle later, together with `out_valid`. In decimal mode the block follows a fixed nibble-correction sequence. N and Z come from the corrected byte, not from the raw binary sum. For operands that are not valid BCD, the output is whatever that same sequence produces.

Top module: `dbalu_top`

## Requirements
- R1: Outputs are registered with one cycle of latency: `out_valid` equals `in_valid` from the previous edge. While `rst` is high at an edge, `out_valid`, `res_o`, all flags and `upd_o` are cleared to zero.
- R2: Operation codes on `op_i` are 0 add, 1 subtract, 2 increment, 3 decrement, 4 bit-test immediate and 5 bit-test memory. Codes 6 and 7 return `res_o` equal to the accumulator, all flags 0 and `upd_o` 0.
- R3: Binary add: {C, result} = A + M + carry_in. V is set when A and M share a sign bit and the result's sign differs from it. N is result bit 7 and Z is set when the result is zero.
- R4: Decimal add works in steps. First, lo = A[3:0] + M[3:0] + carry_in and hi = A[7:4]·16 + M[7:4]·16. When lo > 9, add 6 to lo and 0x10 to hi. Next, when hi > 0x90, add 0x60 to hi. C is set when hi ≥ 0x100. The result is {hi[7:4], lo[3:0]}, and N and Z are taken from that result.
- R5: In decimal add, V is taken from hi after the first correction and before the 0x60 correction. V is set when A and M share a sign bit and bit 7 of that intermediate hi differs from A[7].
- R6: Binary subtract: the result is the low byte of t = A − M − (1 − carry_in). V is bit 7 of (A ^ t) & (A ^ M). N and Z are taken from the result.
- R7: Decimal subtract starts from the same t. If the full difference is negative, 0x60 is removed from t. If A[3:0] < M[3:0] + (1 − carry_in), a further 6 is removed. The result is the low byte, with N and Z taken from it. V is still computed from the uncorrected t.
- R8: After any subtract, C is set exactly when A − (1 − carry_in) ≥ M, taken as integers.
- R9: Increment and decrement return A ± 1 modulo 256, set N and Z from the result, output V = C = 0 and `upd_o` = 4'b1010. Both `carry_i` and `dec_i` have no effect on them.
- R10: Bit-test memory returns `res_o` = A, Z = ((A & M) == 0), N = M[7], V = M[6], C = 0 and `upd_o` = 4'b1110.
- R11: Bit-test immediate returns `res_o` = A, Z = ((A & M) == 0), N = V = C = 0 and `upd_o` = 4'b0010.
- R12: `upd_o` is ordered {N, V, Z, C}. Add and subtract return 4'b1111. Any flag whose mask bit is 0 is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this edge are to be processed |
| op_i | input | 3 | Operation code (see R2) |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand M |
| carry_i | input | 1 | Carry in (for subtract, 0 means borrow) |
| dec_i | input | 1 | Decimal mode select for add and subtract |
| out_valid | output | 1 | Result registers hold a new result |
| res_o | output | 8 | Result byte |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| upd_o | output | 4 | Flag write mask {N, V, Z, C} |

## Verification
The sweep covers every accumulator value against a strided set of operands, with both carry-in values, in both modes. This reaches the low-nibble boundary at 9/10, the high threshold at 0x90 and non-BCD digits A–F. A design that computed decimal V after the 0x60 step, or took Z from the binary sum, would differ on those operands. Subtract sweeps cover A = 0 with borrow, where a carry computed in 8 bits would wrap and report no borrow. Increment and decrement are run with carry and decimal mode set, and wrap at 0x00/0xFF. The bit-test pair is compared on the mask and on N/V, which is where a design that let the immediate form write N or V would show.

// File: rtl/dbalu_pkg.sv
package dbalu_pkg;

    parameter int DW = 8;
    localparam int NW = DW / 2;

    localparam int DIGIT_MAX = 9;
    localparam int NIB_FIX   = 6;
    localparam int HI_LIMIT  = DIGIT_MAX << NW;
    localparam int HI_FIX    = NIB_FIX << NW;

    typedef enum logic [2:0] {
        OP_ADC  = 3'd0,
        OP_SBC  = 3'd1,
        OP_INC  = 3'd2,
        OP_DEC  = 3'd3,
        OP_BITI = 3'd4,
        OP_BITM = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        flags_t        flg;
        flags_t        upd;
    } alu_out_t;

    function automatic logic is_zero(input logic [DW-1:0] x);
        return (x == '0);
    endfunction

    localparam flags_t UPD_ALL  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
    localparam flags_t UPD_NZ   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
    localparam flags_t UPD_NVZ  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
    localparam flags_t UPD_Z    = '{n: 1'b0, v: 1'b0, z: 1'b1, c: 1'b0};
    localparam flags_t UPD_NONE = '{n: 1'b0, v: 1'b0, z: 1'b0, c: 1'b0};

endpackage

// File: rtl/dbalu_add.sv
module dbalu_add
    import dbalu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          dec,
    output alu_out_t      o
);
    localparam int LW = NW + 2;
    localparam int HW = DW + 2;
    localparam int SW = DW + 1;

    logic [SW-1:0] bsum;
    logic [LW-1:0] lo;
    logic [HW-1:0] hi;
    logic          dv;
    logic          dc;
    logic [DW-1:0] dres;

    always_comb begin
        bsum = SW'(a) + SW'(m) + SW'(cin);

        lo = LW'(a[NW-1:0]) + LW'(m[NW-1:0]) + LW'(cin);
        hi = HW'({a[DW-1:NW], {NW{1'b0}}}) + HW'({m[DW-1:NW], {NW{1'b0}}});
        if (lo > LW'(DIGIT_MAX)) begin
            hi = hi + HW'(1 << NW);
            lo = lo + LW'(NIB_FIX);
        end
        dv = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ hi[DW-1]);
        if (hi > HW'(HI_LIMIT)) begin
            hi = hi + HW'(HI_FIX);
        end
        dc   = |hi[HW-1:DW];
        dres = {hi[DW-1:NW], lo[NW-1:0]};

        o.upd = UPD_ALL;
        if (dec) begin
            o.res   = dres;
            o.flg.v = dv;
            o.flg.c = dc;
        end else begin
            o.res   = bsum[DW-1:0];
            o.flg.v = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ bsum[DW-1]);
            o.flg.c = bsum[DW];
        end
        o.flg.n = o.res[DW-1];
        o.flg.z = is_zero(o.res);
    end
endmodule

// File: rtl/dbalu_sub.sv
module dbalu_sub
    import dbalu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          dec,
    output alu_out_t      o
);
    localparam int SW = DW + 1;
    localparam int NB = NW + 1;

    logic          bw;
    logic [SW-1:0] diff;
    logic          neg;
    logic          lo_bw;
    logic [DW-1:0] dres;

    always_comb begin
        bw    = ~cin;
        diff  = SW'(a) - SW'(m) - SW'(bw);
        neg   = diff[DW];
        lo_bw = NB'(a[NW-1:0]) < (NB'(m[NW-1:0]) + NB'(bw));
        dres  = diff[DW-1:0]
              - (neg   ? DW'(HI_FIX)  : '0)
              - (lo_bw ? DW'(NIB_FIX) : '0);

        o.upd   = UPD_ALL;
        o.res   = dec ? dres : diff[DW-1:0];
        o.flg.v = (a[DW-1] ^ diff[DW-1]) & (a[DW-1] ^ m[DW-1]);
        o.flg.c = ~neg;
        o.flg.n = o.res[DW-1];
        o.flg.z = is_zero(o.res);
    end
endmodule

// File: rtl/dbalu_misc.sv
module dbalu_misc
    import dbalu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    output alu_out_t      o
);
    logic [DW-1:0] masked;

    always_comb begin
        masked = a & m;
        o      = '0;
        o.res  = a;
        unique case (op)
            OP_INC, OP_DEC: begin
                o.res   = (op == OP_INC) ? a + DW'(1) : a - DW'(1);
                o.flg.n = o.res[DW-1];
                o.flg.z = is_zero(o.res);
                o.upd   = UPD_NZ;
            end
            OP_BITM: begin
                o.flg.n = m[DW-1];
                o.flg.v = m[DW-2];
                o.flg.z = is_zero(masked);
                o.upd   = UPD_NVZ;
            end
            OP_BITI: begin
                o.flg.z = is_zero(masked);
                o.upd   = UPD_Z;
            end
            default: begin
                o.upd = UPD_NONE;
            end
        endcase
    end
endmodule

// File: rtl/dbalu_top.sv
module dbalu_top
    import dbalu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic          carry_i,
    input  logic          dec_i,
    output logic          out_valid,
    output logic [DW-1:0] res_o,
    output logic          flag_n_o,
    output logic          flag_v_o,
    output logic          flag_z_o,
    output logic          flag_c_o,
    output logic [3:0]    upd_o
);
    alu_op_e  op_e;
    alu_out_t add_o;
    alu_out_t sub_o;
    alu_out_t misc_o;
    alu_out_t sel;
    alu_out_t q;
    logic     vld_q;

    assign op_e = alu_op_e'(op_i);

    dbalu_add u_add (
        .a   (acc_i),
        .m   (opnd_i),
        .cin (carry_i),
        .dec (dec_i),
        .o   (add_o)
    );

    dbalu_sub u_sub (
        .a   (acc_i),
        .m   (opnd_i),
        .cin (carry_i),
        .dec (dec_i),
        .o   (sub_o)
    );

    dbalu_misc u_misc (
        .op (op_e),
        .a  (acc_i),
        .m  (opnd_i),
        .o  (misc_o)
    );

    always_comb begin
        unique case (op_e)
            OP_ADC:  sel = add_o;
            OP_SBC:  sel = sub_o;
            default: sel = misc_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            q     <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                q <= sel;
            end
        end
    end

    assign out_valid = vld_q;
    assign res_o     = q.res;
    assign flag_n_o  = q.flg.n;
    assign flag_v_o  = q.flg.v;
    assign flag_z_o  = q.flg.z;
    assign flag_c_o  = q.flg.c;
    assign upd_o     = q.upd;
endmodule

// File: rtl/dbalu_chk.sv
module dbalu_chk
    import dbalu_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [2:0]    op_i,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] opnd_i,
    input logic          carry_i,
    input logic          dec_i,
    input logic          out_valid,
    input logic [DW-1:0] res_o,
    input logic          flag_n_o,
    input logic          flag_v_o,
    input logic          flag_z_o,
    input logic          flag_c_o,
    input logic [3:0]    upd_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && upd_o == 4'b0000 && res_o == '0));

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_bin_add_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst) && $past(op_i) == 3'd0 && !$past(dec_i))
        |-> ({flag_c_o, res_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}
                                   + {{DW{1'b0}}, $past(carry_i)})));

    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst) && $past(op_i) == 3'd2)
        |-> (res_o == $past(acc_i) + DW'(1) && upd_o == 4'b1010 && !flag_c_o));

    assert_bitmem_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst) && $past(op_i) == 3'd5)
        |-> (flag_n_o == $past(opnd_i[DW-1]) && flag_v_o == $past(opnd_i[DW-2])));

    assert_bitimm_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst) && $past(op_i) == 3'd4)
        |-> (upd_o == 4'b0010 && !flag_n_o && !flag_v_o));

    assert_arith_mask_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst) && ($past(op_i) == 3'd0 || $past(op_i) == 3'd1))
        |-> (upd_o == 4'b1111));

    assert_z_tracks_result_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst) && $past(op_i) <= 3'd3)
        |-> (flag_z_o == (res_o == '0)));
endmodule

bind dbalu_top dbalu_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_i      (op_i),
    .acc_i     (acc_i),
    .opnd_i    (opnd_i),
    .carry_i   (carry_i),
    .dec_i     (dec_i),
    .out_valid (out_valid),
    .res_o     (res_o),
    .flag_n_o  (flag_n_o),
    .flag_v_o  (flag_v_o),
    .flag_z_o  (flag_z_o),
    .flag_c_o  (flag_c_o),
    .upd_o     (upd_o)
);

// File: tb/dbalu_top_tb_top.sv
module dbalu_top_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [2:0] op_i;
    logic [7:0] acc_i;
    logic [7:0] opnd_i;
    logic       carry_i;
    logic       dec_i;
    logic       out_valid;
    logic [7:0] res_o;
    logic       flag_n_o, flag_v_o, flag_z_o, flag_c_o;
    logic [3:0] upd_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    dbalu_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i), .dec_i(dec_i),
        .out_valid(out_valid), .res_o(res_o),
        .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o),
        .flag_c_o(flag_c_o), .upd_o(upd_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Expected values, computed step by step from the requirements
    task automatic model(input int op, input int a, input int m, input int c, input int d,
                         output int res, output int n, output int v, output int z,
                         output int co, output int mask);
        int lo, hi, s, b, t, t2;
        res = a; n = 0; v = 0; z = 0; co = 0; mask = 0;
        case (op)
            0: begin
                mask = 15;
                if (d == 0) begin
                    s = a + m + c;
                    res = s & 255;
                    v = (((~(a ^ m)) & (a ^ s) & 128) != 0) ? 1 : 0;
                    co = (s > 255) ? 1 : 0;
                end else begin
                    lo = (a & 15) + (m & 15) + c;
                    hi = (a & 240) + (m & 240);
                    if (lo > 9) begin hi += 16; lo += 6; end
                    v = (((~(a ^ m)) & (a ^ hi) & 128) != 0) ? 1 : 0;
                    if (hi > 144) hi += 96;
                    co = (hi >= 256) ? 1 : 0;
                    res = (lo & 15) | (hi & 240);
                end
            end
            1: begin
                mask = 15;
                b = 1 - c;
                t = (a - m - b) & 65535;
                v = (((a ^ t) & (a ^ m) & 128) != 0) ? 1 : 0;
                if (d != 0) begin
                    if (t > 255) t = (t - 96) & 65535;
                    t2 = ((a & 15) - (m & 15) - b) & 65535;
                    if (t2 > 255) t -= 6;
                end
                co = ((a - b) >= m) ? 1 : 0;
                res = t & 255;
            end
            2: begin res = (a + 1) & 255; mask = 10; end
            3: begin res = (a - 1) & 255; mask = 10; end
            4: begin z = ((a & m) == 0) ? 1 : 0; mask = 2; end
            5: begin
                z = ((a & m) == 0) ? 1 : 0;
                n = (m >> 7) & 1;
                v = (m >> 6) & 1;
                mask = 14;
            end
            default: begin end
        endcase
        if (op <= 3) begin
            n = (res >> 7) & 1;
            z = (res == 0) ? 1 : 0;
        end
    endtask

    function automatic string base_tag(input int op, input int d);
        case (op)
            0: return (d != 0) ? "R4" : "R3";
            1: return (d != 0) ? "R7" : "R6";
            2, 3: return "R9";
            4: return "R11";
            5: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Drive at a falling edge, let one rising edge capture, check at the next falling edge
    task automatic run_vec(input int op, input int a, input int m, input int c, input int d);
        int er, en, ev, ez, ec, emask;
        string bt;
        in_valid = 1'b1;
        op_i     = 3'(op);
        acc_i    = 8'(a);
        opnd_i   = 8'(m);
        carry_i  = c[0];
        dec_i    = d[0];
        @(posedge clk);
        @(negedge clk);
        model(op, a, m, c, d, er, en, ev, ez, ec, emask);
        bt = base_tag(op, d);
        check("R1", "out_valid", 16'(out_valid), 16'd1);
        check(bt, "result", 16'(res_o), 16'(er));
        check(bt, "N/Z", 16'({flag_n_o, flag_z_o}), 16'({en[0], ez[0]}));
        check((op == 0 && d != 0) ? "R5" : bt, "V", 16'(flag_v_o), 16'(ev));
        check((op == 1) ? "R8" : bt, "C", 16'(flag_c_o), 16'(ec));
        check("R12", "mask", 16'(upd_o), 16'(emask));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_i = '0; acc_i = '0; opnd_i = '0;
        carry_i = 1'b0; dec_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset out_valid", 16'(out_valid), 16'd0);
        check("R1", "reset result", 16'(res_o), 16'd0);
        check("R1", "reset flags", 16'({flag_n_o, flag_v_o, flag_z_o, flag_c_o}), 16'd0);
        check("R1", "reset mask", 16'(upd_o), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "idle out_valid", 16'(out_valid), 16'd0);

        // Directed decimal cases: 58+46+1 = 105, 46-12 = 34, 00-01 = 99 with borrow
        run_vec(0, 'h58, 'h46, 1, 1);
        check("R4", "bcd add", 16'({flag_c_o, res_o}), 16'h105);
        run_vec(1, 'h46, 'h12, 1, 1);
        check("R7", "bcd sub", 16'({flag_c_o, res_o}), 16'h134);
        run_vec(1, 'h00, 'h01, 1, 1);
        check("R8", "bcd sub wrap", 16'({flag_c_o, res_o}), 16'h099);

        // Add and subtract: all A, strided M, both carries, both modes
        for (int op = 0; op < 2; op++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 256; a++)
                        for (int m = 0; m < 256; m += 5)
                            run_vec(op, a, m, c, d);

        // Increment / decrement, carry and decimal mode must not matter (R9)
        for (int op = 2; op < 4; op++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 256; a++)
                        run_vec(op, a, 'h5a, c, d);

        // Bit tests (R10, R11) and reserved codes (R2)
        for (int op = 4; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int m = 0; m < 256; m += 17)
                    run_vec(op, a, m, a & 1, (a >> 1) & 1);

        // R1: out_valid drops one cycle after in_valid does
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "valid drop", 16'(out_valid), 16'd0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule